// File: doc/BRIEF.md
# Windowed Single-Bin DFT Correlator

This block measures the response of a driven load at one excitation frequency. It takes a stream of 12-bit ADC samples and weights each one with a triangular window. It then multiplies the weighted sample by the cosine and by the negated sine of a reference phasor that follows the excitation. Both products are summed over a block of 1024 samples. When the block closes, the block returns one frequency bin of a discrete Fourier transform as a pair of signed 16-bit words, real and imaginary, with a one-cycle valid strobe.

A sweep controller sets the excitation to each frequency point in turn. For every sample it supplies the current phase index of the excitation oscillator, and it pulses `start` when a new point should begin from a clean state. Blocks follow one another without idle cycles, so holding the frequency steady yields a new result pair every 1024 accepted samples. The window coefficients and the phasor table are built inside the block. Magnitude, phase angle and calibration are computed downstream.

Top module: `dft_bin_correlator`

## Requirements
- R1: A block holds exactly 1024 accepted samples. A sample is accepted in a cycle where `smp_valid` is high and `start` is low. Cycles with `smp_valid` low leave the block position unchanged.
- R2: The accepted sample with index n (counted from 0 within its block) is weighted by w(n) = n for n < 512 and by w(n) = 1023 − n for n ≥ 512.
- R3: `smp_data` is a signed 12-bit two's-complement value. `ref_phase` is an 8-bit phase index i taken in the same cycle as the sample. The table sine is s(i) = m for i < 128 and s(i) = −m otherwise, where h = i mod 128 and m = floor(h·(128 − h)/2). The table cosine is c(i) = s((i + 64) mod 256).
- R4: Over a block, the real sum accumulates x·w(n)·c(i) and the imaginary sum accumulates −x·w(n)·s(i). Both sums are exact.
- R5: Each output word is floor(sum / 2^RES_SHIFT), with RES_SHIFT = 24 by default. The value is clamped to the range −32768 to 32767 and given as 16-bit two's complement.
- R6: `out_valid` is high for exactly one cycle per completed block. That cycle is the second cycle after the cycle in which the 1024th sample is presented.
- R7: `out_re` and `out_im` change only in the cycle in which `out_valid` is high. At all other times they hold their last value.
- R8: The first sample accepted after a block completes opens a new block at index 0 with both sums at zero. This needs no idle cycle between blocks.
- R9: A cycle with `start` high clears both sums and the block index. A sample presented in that same cycle is discarded.
- R10: If `start` is high in the cycle right after the 1024th sample, that block's result is cancelled. `out_valid` stays low and the outputs keep their previous values.
- R11: A synchronous active-high `rst` drives `out_valid` low and both outputs to zero, and it clears the sums and the block index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restart the current frequency point |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Signed ADC sample |
| ref_phase | input | 8 | Phase index of the excitation for this sample |
| out_valid | output | 1 | One-cycle strobe for a new result pair |
| out_re | output | 16 | Signed real part of the bin |
| out_im | output | 16 | Signed imaginary part of the bin |

## Verification
The bench drives full-scale samples of both signs at phase indices 0 and 64. These cases hit both clamp limits and the sign of the negated sine term. A design that wraps instead of clamping, or that swaps the sine and cosine, returns values of the wrong sign or size. Blocks run back to back with random gaps in `smp_valid`. A counter that advances on idle cycles, or that fails to clear the sums between blocks, closes the block at the wrong sample or carries part of one sum into the next. `start` is exercised mid-block with a coincident sample and also in the single cycle after a block's last sample. A design that keeps the coincident sample, or that lets the in-flight result through, shows a stray value or a stray `out_valid` pulse.

// File: rtl/dftc_pkg.sv
package dftc_pkg;

    localparam int SMP_W    = 12;
    localparam int BLK_LOG  = 10;
    localparam int BLK_LEN  = 1 << BLK_LOG;
    localparam int WIN_W    = BLK_LOG - 1;
    localparam int TBL_W    = 8;
    localparam int TBL_LEN  = 1 << TBL_W;
    localparam int TBL_HALF = TBL_LEN / 2;
    localparam int TBL_QTR  = TBL_LEN / 4;
    localparam int COEF_W   = 13;
    localparam int SINE_SHR = 2 * TBL_W - COEF_W - 2;
    localparam int XW_W     = SMP_W + WIN_W + 1;
    localparam int PROD_W   = XW_W + COEF_W;
    localparam int ACC_W    = PROD_W + BLK_LOG;
    localparam int RES_W    = 16;
    localparam int N_LANE   = 2;

    typedef logic signed [COEF_W-1:0] coef_t;

    // one windowed sample on its way to the accumulators
    typedef struct packed {
        logic                   vld;
        logic                   last;
        logic signed [XW_W-1:0] xw;
        coef_t                  cos_c;
        coef_t                  nsin_c;
    } tap_t;

    // triangular weight: rises over the first half, falls over the second
    function automatic logic [WIN_W-1:0] tri_win(input logic [BLK_LOG-1:0] n);
        return n[BLK_LOG-1] ? ~n[WIN_W-1:0] : n[WIN_W-1:0];
    endfunction

    // parabolic half-wave per half period, sign from the top index bit
    function automatic coef_t sine_at(input logic [TBL_W-1:0] i);
        logic [TBL_W-2:0]   h;
        logic [TBL_W-1:0]   d;
        logic [2*TBL_W-1:0] m;
        coef_t              v;
        h = i[TBL_W-2:0];
        d = TBL_W'(TBL_HALF) - {1'b0, h};
        m = (2*TBL_W)'(h) * (2*TBL_W)'(d);
        v = COEF_W'(m >> SINE_SHR);
        return i[TBL_W-1] ? -v : v;
    endfunction

    // keep the low RES_W bits when they represent the value, else clamp
    function automatic logic signed [RES_W-1:0] sat_res(input logic signed [ACC_W-1:0] v);
        logic [ACC_W-RES_W:0] top;
        top = v[ACC_W-1:RES_W-1];
        if (top == '0 || top == '1)
            return v[RES_W-1:0];
        return v[ACC_W-1] ? {1'b1, {(RES_W-1){1'b0}}} : {1'b0, {(RES_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/dftc_phasor.sv
module dftc_phasor
    import dftc_pkg::*;
(
    input  logic [TBL_W-1:0] idx,
    output coef_t            cos_c,
    output coef_t            nsin_c
);

    coef_t            rom [TBL_LEN];
    logic [TBL_W-1:0] idx_cos;

    for (genvar g = 0; g < TBL_LEN; g++) begin : g_rom
        assign rom[g] = sine_at(TBL_W'(g));
    end

    assign idx_cos = idx + TBL_W'(TBL_QTR);
    assign cos_c   = rom[idx_cos];
    assign nsin_c  = -rom[idx];

endmodule

// File: rtl/dftc_front.sv
module dftc_front
    import dftc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [TBL_W-1:0] ph_idx,
    output tap_t             tap
);

    localparam logic [BLK_LOG-1:0] LAST_IDX = BLK_LOG'(BLK_LEN - 1);

    logic [BLK_LOG-1:0]     cnt;
    logic [WIN_W-1:0]       win;
    logic signed [XW_W-1:0] xw;
    coef_t                  cos_c;
    coef_t                  nsin_c;

    assign win = tri_win(cnt);
    assign xw  = XW_W'($signed(smp_data)) * XW_W'($signed({1'b0, win}));

    dftc_phasor u_phasor (
        .idx    (ph_idx),
        .cos_c  (cos_c),
        .nsin_c (nsin_c)
    );

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt <= '0;
            tap <= '0;
        end else begin
            tap.vld    <= smp_valid;
            tap.last   <= smp_valid && (cnt == LAST_IDX);
            tap.xw     <= xw;
            tap.cos_c  <= cos_c;
            tap.nsin_c <= nsin_c;
            if (smp_valid)
                cnt <= cnt + 1'b1;
        end
    end

    // R9: restart leaves index zero and nothing in flight
    a_r9_start_clears_index: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt == '0 && !tap.vld));

    // R8: block end wraps the index and flags the closing sample
    a_r8_block_wraps: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !start && cnt == LAST_IDX) |=> (cnt == '0 && tap.last));

endmodule

// File: rtl/dftc_accum.sv
module dftc_accum
    import dftc_pkg::*;
#(
    parameter int RES_SHIFT = 24
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    vld,
    input  logic                    last,
    input  logic signed [XW_W-1:0]  xw,
    input  coef_t                   coef,
    output logic signed [RES_W-1:0] res,
    output logic                    res_valid
);

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  sum;
    logic signed [ACC_W-1:0]  scaled;

    assign prod   = PROD_W'(xw) * PROD_W'(coef);
    assign sum    = acc + ACC_W'(prod);
    assign scaled = sum >>> RES_SHIFT;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            res       <= '0;
            res_valid <= 1'b0;
        end else if (clr) begin
            acc       <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= vld && last;
            if (vld) begin
                if (last) begin
                    acc <= '0;
                    res <= sat_res(scaled);
                end else begin
                    acc <= sum;
                end
            end
        end
    end

    // R10: a restart never lets a result out on the next cycle
    a_r10_clear_drops_result: assert property (@(posedge clk) disable iff (rst)
        clr |=> !res_valid);

    // R7: the result only moves together with its strobe
    a_r7_result_held: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(res));

endmodule

// File: rtl/dft_bin_correlator.sv
module dft_bin_correlator
    import dftc_pkg::*;
#(
    parameter int RES_SHIFT = 24
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [TBL_W-1:0] ref_phase,
    output logic             out_valid,
    output logic [RES_W-1:0] out_re,
    output logic [RES_W-1:0] out_im
);

    tap_t                    tap;
    logic [N_LANE-1:0]       lane_vld;
    logic signed [RES_W-1:0] lane_res [N_LANE];

    dftc_front u_front (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .ph_idx    (ref_phase),
        .tap       (tap)
    );

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        coef_t lane_coef;
        if (g == 0) begin : g_real
            assign lane_coef = tap.cos_c;
        end else begin : g_imag
            assign lane_coef = tap.nsin_c;
        end
        dftc_accum #(.RES_SHIFT(RES_SHIFT)) u_acc (
            .clk       (clk),
            .rst       (rst),
            .clr       (start),
            .vld       (tap.vld),
            .last      (tap.last),
            .xw        (tap.xw),
            .coef      (lane_coef),
            .res       (lane_res[g]),
            .res_valid (lane_vld[g])
        );
    end

    assign out_valid = &lane_vld;
    assign out_re    = lane_res[0];
    assign out_im    = lane_res[1];

    // R6: strobe lasts a single cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R6: strobe follows the closing sample leaving the front stage
    a_r6_follows_last: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(tap.vld && tap.last));

endmodule

// File: tb/test_dft_bin_correlator.sv
module test_dft_bin_correlator;

    localparam int SHIFT = 24;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        smp_valid;
    logic [11:0] smp_data;
    logic [7:0]  ref_phase;
    logic        out_valid;
    logic [15:0] out_re;
    logic [15:0] out_im;

    int    n_vec  = 0;
    int    n_bad  = 0;
    bit    done   = 1'b0;
    string req    = "R11";
    int    ph_run = 0;

    longint      acc_re, acc_im;
    int          cnt;
    bit          pend, exp_v;
    logic [15:0] pend_re, pend_im, hold_re, hold_im;

    dft_bin_correlator #(.RES_SHIFT(SHIFT)) i_dft_bin_correlator (.*);

    always #5 clk = ~clk;

    function automatic int win_of(int n);
        return (n < 512) ? n : 1023 - n;
    endfunction

    function automatic int sin_of(int i);
        int h, m;
        h = i % 128;
        m = (h * (128 - h)) / 2;
        return (i >= 128) ? -m : m;
    endfunction

    function automatic int cos_of(int i);
        return sin_of((i + 64) % 256);
    endfunction

    function automatic logic [15:0] clamp(longint a);
        longint v;
        v = a >>> SHIFT;
        if (v > 32767)  v = 32767;
        if (v < -32768) v = -32768;
        return 16'(v);
    endfunction

    task automatic step(input bit r, input bit st, input bit v, input int x, input int ph);
        int p;
        p = ph & 255;
        rst = r; start = st; smp_valid = v;
        smp_data = 12'(x); ref_phase = 8'(p);
        @(posedge clk);
        if (r) begin
            acc_re = 0; acc_im = 0; cnt = 0; pend = 0; exp_v = 0;
            hold_re = '0; hold_im = '0;
        end else begin
            exp_v = pend && !st;
            if (exp_v) begin
                hold_re = pend_re;
                hold_im = pend_im;
            end
            pend = 0;
            if (st) begin
                acc_re = 0; acc_im = 0; cnt = 0;
            end else if (v) begin
                acc_re += longint'(x) * win_of(cnt) * cos_of(p);
                acc_im -= longint'(x) * win_of(cnt) * sin_of(p);
                cnt++;
                if (cnt == 1024) begin
                    pend = 1; pend_re = clamp(acc_re); pend_im = clamp(acc_im);
                    acc_re = 0; acc_im = 0; cnt = 0;
                end
            end
        end
        @(negedge clk);
        n_vec++;
        if (out_valid !== exp_v || out_re !== hold_re || out_im !== hold_im) begin
            n_bad++;
            $display("FAIL %s: valid/re/im got %0b/%0d/%0d expected %0b/%0d/%0d",
                     req, out_valid, $signed(out_re), $signed(out_im),
                     exp_v, $signed(hold_re), $signed(hold_im));
        end
    endtask

    task automatic feed(input int count, input int xmode, input int xconst,
                        input int ph_step, input bit gaps);
        for (int k = 0; k < count; k++) begin
            int x;
            if (gaps)
                while ($urandom % 2 == 0) step(0, 0, 0, 0, ph_run);
            x = (xmode == 0) ? xconst : int'($urandom % 4096) - 2048;
            step(0, 0, 1, x, ph_run);
            ph_run = (ph_run + ph_step) % 256;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0);
    endtask

    initial begin
        req = "R11 reset state";
        repeat (3) step(1, 0, 0, 0, 0);
        idle(2);

        req = "R1 R2 R4 R6 unit samples at phase 0";
        ph_run = 0;   feed(1024, 0, 1, 0, 0);     idle(3);

        req = "R2 R3 R4 R7 constant negative sample at phase 40";
        ph_run = 40;  feed(1024, 0, -300, 0, 0);  idle(3);

        req = "R5 positive clamp";
        ph_run = 0;   feed(1024, 0, 2047, 0, 0);  idle(2);

        req = "R5 negative clamp";
        ph_run = 0;   feed(1024, 0, -2048, 0, 0); idle(2);

        req = "R3 R4 R5 quarter-turn phase, negated sine";
        ph_run = 64;  feed(1024, 0, 2047, 0, 0);  idle(2);

        req = "R3 R4 rotating phasor, random samples";
        ph_run = 0;   feed(1024, 1, 0, 8, 0);     idle(2);

        req = "R1 R8 back-to-back blocks with strobe gaps";
        ph_run = 17;  feed(2048, 1, 0, 13, 1);    idle(2);

        req = "R8 back-to-back blocks without gaps";
        ph_run = 3;   feed(2048, 1, 0, 29, 0);    idle(2);

        req = "R9 start mid-block drops coincident sample";
        ph_run = 0;   feed(300, 1, 0, 5, 0);
        step(0, 1, 1, 1500, ph_run);
        feed(1024, 1, 0, 5, 0);                   idle(2);

        req = "R10 start after closing sample cancels result";
        ph_run = 0;   feed(1024, 1, 0, 3, 0);
        step(0, 1, 0, 0, 0);                      idle(3);
        feed(1024, 0, 500, 0, 0);                 idle(2);

        req = "R11 reset mid-block";
        feed(100, 1, 0, 7, 0);
        step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
        ph_run = 9;   feed(1024, 1, 0, 11, 0);    idle(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (%s): got no end of run, expected end", req);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule